// File: doc/BRIEF.md
# Combined SPI and Parallel-Serialize Master

This block is a serial link master that carries two kinds of traffic over a single MOSI/MISO/SCK link. Command frames are queued by the host in a transmit FIFO. Serialize frames are produced automatically whenever a parallel input word changes. A small arbiter decides, at each frame boundary, which kind goes next. It then picks the attribute set (frame length and SCK divider) and drives the matching chip select before the frame engine shifts the frame out.

Data clocked in during a serialize frame is delivered to a registered parallel output. Data clocked in during a command frame is pushed into a receive FIFO. A sticky flag records any receive word lost because that FIFO was full. The block runs only while it is configured as link master and its 2-bit mode field selects the combined mode.

Each transmit FIFO entry is 32 bits wide. Bits 25:24 hold the attribute selector. Bits 21:16 hold a chip-select mask, one bit per line. Bits 15:0 hold the data. Each of the four attribute sets has a 5-bit frame length (valid range 4 to 16) and a 4-bit divider.

Top module: `dual_frame_spi_master`

## Requirements
- R1: A frame starts only while `master_en` is 1 and `mode_sel` equals 2'b10. In any other setting no new frame starts and `cs_n` stays all ones, while a frame already under way finishes.
- R2: When the engine is idle and the transmit FIFO holds at least one entry, the next frame is a command frame, even if a serialize request is also pending.
- R3: A serialize frame is requested whenever `par_in` differs from the value last serialized (reset value 0). It starts on an idle edge at which the transmit FIFO is empty, so serialize traffic resumes once command traffic drains.
- R4: A command frame takes its length and divider from attribute set `cmd[25:24]`. A serialize frame takes them from attribute set `par_attr_sel`. Set k occupies `attr_len[5k+4:5k]` and `attr_div[4k+3:4k]`.
- R5: A frame of N bits sends data bits N-1 down to 0, MSB first. SCK idles low. MOSI is valid before each rising edge and changes after each falling edge. MISO is sampled at each rising edge. Each SCK half period lasts divider+1 clocks.
- R6: A serialize frame drives exactly `cs_n[par_cs_idx]` low. A command frame drives low the lines set in mask `cmd[21:16]`, except line `par_cs_idx`, which stays high. All lines are high between frames for at least one clock.
- R7: The N bits received in a serialize frame appear right-aligned, with upper bits zero, on `par_out` one clock after `cs_n` returns high.
- R8: The N bits received in a command frame are pushed, right-aligned, into the receive FIFO one clock after `cs_n` returns high. `rx_data` shows the oldest entry whenever `rx_empty` is 0.
- R9: The transmit FIFO holds 4 entries. `tx_full` is 1 when it holds 4, and a push while full is ignored.
- R10: The receive FIFO holds 4 entries. A command-frame result that arrives while it is full is dropped, and `rx_ovf` goes to 1 and stays there until reset.
- R11: During and right after reset: `sck` = 0, `mosi` = 0, `cs_n` all ones, `par_out` = 0, `rx_empty` = 1, `tx_full` = 0, `rx_ovf` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 2 | Configuration field; 2'b10 selects combined operation |
| master_en | input | 1 | 1 when configured as link master |
| attr_len | input | 20 | Four packed 5-bit frame lengths |
| attr_div | input | 16 | Four packed 4-bit SCK dividers |
| par_attr_sel | input | 2 | Attribute set used by serialize frames |
| par_cs_idx | input | 3 | Chip-select line used by serialize frames |
| tx_push | input | 1 | Write one entry into the transmit FIFO |
| tx_word | input | 32 | Command/data entry to write |
| tx_full | output | 1 | Transmit FIFO full |
| par_in | input | 16 | Parallel word to serialize |
| par_out | output | 16 | Data returned by the last serialize frame |
| rx_pop | input | 1 | Remove the oldest receive FIFO entry |
| rx_data | output | 16 | Oldest receive FIFO entry |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_ovf | output | 1 | Sticky receive overflow flag |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 6 | Chip selects, active low |

## Verification
The frame start, its chip selects and its first MOSI bit take effect on the first edge at which the engine is idle and a request is visible. SCK then toggles every divider+1 clocks. `par_out` and the receive FIFO change exactly one clock after the chip selects return high, and FIFO flags follow a push or pop on the next edge. A behavioural reference model advances on the same rising edge, using input values driven a quarter period after the edge. Every output is compared with that model on each falling edge, so each result is checked in the cycle it is due and never a cycle early or late.

// File: rtl/dfm_pkg.sv
package dfm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOW  = 2'd1,
      ST_HIGH = 2'd2
   } eng_state_t;

   typedef enum logic {
      FR_CMD = 1'b0,
      FR_SER = 1'b1
   } frame_kind_t;

   localparam logic [1:0] COMBINED_MODE = 2'b10;
endpackage

// File: rtl/dfm_fifo.sv
module dfm_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 4,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("dfm_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] rd_ptr, wr_ptr;
   logic [CW-1:0] count;
   logic          do_push, do_pop;

   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign rdata   = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push)
            wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         if (do_pop)
            rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
         if (do_push && !do_pop)
            count <= count + 1'b1;
         else if (do_pop && !do_push)
            count <= count - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push)
         mem[wr_ptr] <= wdata;
   end

   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   // R9
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full && push && !pop |=> full);
endmodule

// File: rtl/dfm_attr_sel.sv
module dfm_attr_sel
   import dfm_pkg::*;
#(
   parameter int NATTR = 4,
   parameter int LENW  = 5,
   parameter int DIVW  = 4,
   parameter int NCS   = 6,
   localparam int SELW = $clog2(NATTR),
   localparam int CSIW = $clog2(NCS)
) (
   input  logic [NATTR*LENW-1:0] attr_len,
   input  logic [NATTR*DIVW-1:0] attr_div,
   input  logic [SELW-1:0]       sel,
   input  frame_kind_t           kind,
   input  logic [NCS-1:0]        cmd_mask,
   input  logic [CSIW-1:0]       ser_cs_idx,
   output logic [LENW-1:0]       len,
   output logic [DIVW-1:0]       div,
   output logic [NCS-1:0]        cs_mask
);
   logic [NCS-1:0] ser_onehot;

   for (genvar i = 0; i < NCS; i++) begin : g_cs_dec
      assign ser_onehot[i] = (ser_cs_idx == CSIW'(i));
   end

   assign len     = attr_len[sel*LENW +: LENW];
   assign div     = attr_div[sel*DIVW +: DIVW];
   // the serialize line is never shared with a command frame
   assign cs_mask = (kind == FR_SER) ? ser_onehot : (cmd_mask & ~ser_onehot);
endmodule

// File: rtl/dfm_engine.sv
module dfm_engine
   import dfm_pkg::*;
#(
   parameter int DW   = 16,
   parameter int LENW = 5,
   parameter int DIVW = 4,
   parameter int NCS  = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  frame_kind_t     kind_in,
   input  logic [DW-1:0]   data_in,
   input  logic [LENW-1:0] len_in,
   input  logic [DIVW-1:0] div_in,
   input  logic [NCS-1:0]  cs_in,
   input  logic            miso,
   output logic            busy,
   output logic            done,
   output frame_kind_t     kind,
   output logic [DW-1:0]   rx_word,
   output logic            sck,
   output logic            mosi,
   output logic [NCS-1:0]  cs_n
);
   eng_state_t      state;
   logic [DIVW-1:0] cnt, div_q;
   logic [LENW-1:0] bits_left;
   logic [DW-1:0]   sh_tx, sh_rx;
   logic            phase_end;

   assign phase_end = (cnt == div_q);
   assign busy      = (state != ST_IDLE);
   assign mosi      = busy & sh_tx[DW-1];
   assign rx_word   = sh_rx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         div_q     <= '0;
         bits_left <= '0;
         sh_tx     <= '0;
         sh_rx     <= '0;
         sck       <= 1'b0;
         cs_n      <= '1;
         done      <= 1'b0;
         kind      <= FR_CMD;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  state     <= ST_LOW;
                  cnt       <= '0;
                  div_q     <= div_in;
                  bits_left <= len_in - 1'b1;
                  sh_tx     <= data_in << (LENW'(DW) - len_in);
                  sh_rx     <= '0;
                  cs_n      <= ~cs_in;
                  kind      <= kind_in;
               end
            end
            ST_LOW: begin
               if (phase_end) begin
                  cnt   <= '0;
                  sck   <= 1'b1;
                  sh_rx <= {sh_rx[DW-2:0], miso};
                  state <= ST_HIGH;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_HIGH: begin
               if (phase_end) begin
                  cnt <= '0;
                  sck <= 1'b0;
                  if (bits_left == '0) begin
                     state <= ST_IDLE;
                     cs_n  <= '1;
                     done  <= 1'b1;
                  end else begin
                     bits_left <= bits_left - 1'b1;
                     sh_tx     <= sh_tx << 1;
                     state     <= ST_LOW;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R5
   sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sck);

   // R6
   cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (cs_n == '1));

   // R5
   len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy |-> (len_in >= LENW'(4)) && (len_in <= LENW'(DW)));
endmodule

// File: rtl/dual_frame_spi_master.sv
module dual_frame_spi_master
   import dfm_pkg::*;
#(
   parameter int DW    = 16,
   parameter int NCS   = 6,
   parameter int NATTR = 4,
   parameter int DIVW  = 4,
   parameter int DEPTH = 4,
   localparam int LENW = $clog2(DW + 1),
   localparam int SELW = $clog2(NATTR),
   localparam int CSIW = $clog2(NCS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            mode_sel,
   input  logic                  master_en,
   input  logic [NATTR*LENW-1:0] attr_len,
   input  logic [NATTR*DIVW-1:0] attr_div,
   input  logic [SELW-1:0]       par_attr_sel,
   input  logic [CSIW-1:0]       par_cs_idx,
   input  logic                  tx_push,
   input  logic [2*DW-1:0]       tx_word,
   output logic                  tx_full,
   input  logic [DW-1:0]         par_in,
   output logic [DW-1:0]         par_out,
   input  logic                  rx_pop,
   output logic [DW-1:0]         rx_data,
   output logic                  rx_empty,
   output logic                  rx_ovf,
   output logic                  sck,
   output logic                  mosi,
   input  logic                  miso,
   output logic [NCS-1:0]        cs_n
);
   localparam int CMD_CS_LSB  = DW;
   localparam int CMD_SEL_LSB = DW + 8;

   if (NCS > 8 || NCS < 2) begin : g_bad_ncs
      $error("dual_frame_spi_master: NCS must be 2..8");
   end
   if (DW < 8 + SELW || DW < 4) begin : g_bad_dw
      $error("dual_frame_spi_master: DW too small for command field");
   end

   logic            active, eng_busy, eng_done;
   logic            start_cmd, start_ser, tx_empty, rx_full, rx_push;
   frame_kind_t     start_kind, eng_kind;
   logic [2*DW-1:0] tx_head;
   logic [DW-1:0]   last_ser, start_data, eng_rx;
   logic [SELW-1:0] start_sel;
   logic [LENW-1:0] start_len;
   logic [DIVW-1:0] start_div;
   logic [NCS-1:0]  start_cs;
   logic            unused_cmd_bits;

   assign unused_cmd_bits = ^tx_head;

   // frame-boundary arbitration
   assign active     = master_en && (mode_sel == COMBINED_MODE);
   assign start_cmd  = active && !eng_busy && !tx_empty;
   assign start_ser  = active && !eng_busy && tx_empty && (par_in != last_ser);
   assign start_kind = start_cmd ? FR_CMD : FR_SER;
   assign start_sel  = start_cmd ? tx_head[CMD_SEL_LSB +: SELW] : par_attr_sel;
   assign start_data = start_cmd ? tx_head[DW-1:0] : par_in;
   assign rx_push    = eng_done && (eng_kind == FR_CMD);

   dfm_fifo #(.W(2*DW), .DEPTH(DEPTH)) u_tx_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (tx_push),
      .wdata (tx_word),
      .pop   (start_cmd),
      .rdata (tx_head),
      .empty (tx_empty),
      .full  (tx_full)
   );

   dfm_attr_sel #(.NATTR(NATTR), .LENW(LENW), .DIVW(DIVW), .NCS(NCS)) u_attr (
      .attr_len   (attr_len),
      .attr_div   (attr_div),
      .sel        (start_sel),
      .kind       (start_kind),
      .cmd_mask   (tx_head[CMD_CS_LSB +: NCS]),
      .ser_cs_idx (par_cs_idx),
      .len        (start_len),
      .div        (start_div),
      .cs_mask    (start_cs)
   );

   dfm_engine #(.DW(DW), .LENW(LENW), .DIVW(DIVW), .NCS(NCS)) u_engine (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start_cmd || start_ser),
      .kind_in (start_kind),
      .data_in (start_data),
      .len_in  (start_len),
      .div_in  (start_div),
      .cs_in   (start_cs),
      .miso    (miso),
      .busy    (eng_busy),
      .done    (eng_done),
      .kind    (eng_kind),
      .rx_word (eng_rx),
      .sck     (sck),
      .mosi    (mosi),
      .cs_n    (cs_n)
   );

   dfm_fifo #(.W(DW), .DEPTH(DEPTH)) u_rx_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rx_push),
      .wdata (eng_rx),
      .pop   (rx_pop),
      .rdata (rx_data),
      .empty (rx_empty),
      .full  (rx_full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_ser <= '0;
         par_out  <= '0;
         rx_ovf   <= 1'b0;
      end else begin
         if (start_ser)
            last_ser <= par_in;
         if (eng_done && eng_kind == FR_SER)
            par_out <= eng_rx;
         if (rx_push && rx_full)
            rx_ovf <= 1'b1;
      end
   end

   // R1
   mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active && !eng_busy |=> !eng_busy);

   // R2
   cmd_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eng_busy) |-> ((eng_kind == FR_CMD) == $past(!tx_empty)));

   // R6
   ser_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_busy && eng_kind == FR_SER |-> $countones(~cs_n) == 1);

   // R6
   cmd_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_busy && eng_kind == FR_CMD |-> cs_n[par_cs_idx]);

   // R10
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ovf |=> rx_ovf);
endmodule

// File: tb/dual_frame_spi_master_tb_top.sv
module dual_frame_spi_master_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode_sel = 2'b00;
   logic        master_en = 1'b0;
   logic [19:0] attr_len = {5'd12, 5'd4, 5'd8, 5'd16};
   logic [15:0] attr_div = {4'd0, 4'd2, 4'd1, 4'd0};
   logic [1:0]  par_attr_sel = 2'd1;
   logic [2:0]  par_cs_idx = 3'd2;
   logic        tx_push = 1'b0;
   logic [31:0] tx_word = '0;
   logic [15:0] par_in = '0;
   logic        rx_pop = 1'b0;
   logic        miso = 1'b0;
   logic        tx_full, rx_empty, rx_ovf, sck, mosi;
   logic [15:0] par_out, rx_data;
   logic [5:0]  cs_n;

   dual_frame_spi_master dut_i (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .master_en(master_en),
      .attr_len(attr_len), .attr_div(attr_div), .par_attr_sel(par_attr_sel),
      .par_cs_idx(par_cs_idx), .tx_push(tx_push), .tx_word(tx_word),
      .tx_full(tx_full), .par_in(par_in), .par_out(par_out), .rx_pop(rx_pop),
      .rx_data(rx_data), .rx_empty(rx_empty), .rx_ovf(rx_ovf), .sck(sck),
      .mosi(mosi), .miso(miso), .cs_n(cs_n)
   );

   always #10 clk = ~clk;

   int compared = 0;
   int mismatched = 0;
   int cycles = 0;

   task automatic chk(string req, string nm, logic [31:0] act, logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %h expected %h at %0t", req, nm, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int          lenA [4] = '{16, 8, 4, 12};
   int          divA [4] = '{0, 1, 2, 0};
   logic [31:0] txq [$];
   logic [15:0] rxq [$];
   int          m_st, m_cnt, m_div, m_bit, p_tx, p_rx;
   logic        m_kind, m_pend, m_pkind, m_sck, m_ovf, m_act, rx_add;
   logic [15:0] m_word, m_rx, m_prx, m_par, m_last, rx_val;
   logic [5:0]  m_cs, one_hot;
   logic [31:0] w;

   always @(posedge clk) begin
      if (!rst_n) begin
         txq.delete(); rxq.delete();
         m_st = 0; m_cnt = 0; m_div = 0; m_bit = 0; m_kind = 0;
         m_pend = 0; m_pkind = 0; m_sck = 0; m_ovf = 0;
         m_word = 0; m_rx = 0; m_prx = 0; m_par = 0; m_last = 0; m_cs = 6'h3f;
      end else begin
         p_tx = txq.size();
         p_rx = rxq.size();
         m_act = (mode_sel == 2'b10) && master_en;
         one_hot = 6'(1 << par_cs_idx);
         rx_add = 0;
         if (m_pend) begin
            m_pend = 0;
            if (m_pkind) m_par = m_prx;
            else if (p_rx < 4) begin rx_add = 1; rx_val = m_prx; end
            else m_ovf = 1;
         end
         if (m_st == 0) begin
            if (m_act && p_tx > 0) begin
               w = txq.pop_front();
               m_kind = 0; m_word = w[15:0];
               m_bit = lenA[w[25:24]] - 1; m_div = divA[w[25:24]];
               m_cs = ~(w[21:16] & ~one_hot);
               m_st = 1; m_cnt = 0; m_rx = 0;
            end else if (m_act && par_in != m_last) begin
               m_last = par_in;
               m_kind = 1; m_word = par_in;
               m_bit = lenA[par_attr_sel] - 1; m_div = divA[par_attr_sel];
               m_cs = ~one_hot;
               m_st = 1; m_cnt = 0; m_rx = 0;
            end
         end else if (m_st == 1) begin
            if (m_cnt == m_div) begin
               m_cnt = 0; m_st = 2; m_sck = 1; m_rx = {m_rx[14:0], miso};
            end else m_cnt++;
         end else begin
            if (m_cnt == m_div) begin
               m_cnt = 0; m_sck = 0;
               if (m_bit == 0) begin
                  m_st = 0; m_cs = 6'h3f;
                  m_pend = 1; m_pkind = m_kind; m_prx = m_rx;
               end else begin
                  m_bit--; m_st = 1;
               end
            end else m_cnt++;
         end
         if (rx_pop && p_rx > 0) void'(rxq.pop_front());
         if (rx_add) rxq.push_back(rx_val);
         if (tx_push && p_tx < 4) txq.push_back(tx_word);
      end
   end

   // compare every output on each falling edge
   always @(negedge clk) begin
      if (cycles > 0) begin
         chk("R4 R5", "sck", 32'(sck), 32'(m_sck));
         chk("R4 R5", "mosi", 32'(mosi), 32'((m_st != 0) ? m_word[m_bit] : 1'b0));
         chk("R1 R2 R3 R6", "cs_n", 32'(cs_n), 32'(m_cs));
         chk("R7", "par_out", 32'(par_out), 32'(m_par));
         chk("R8", "rx_empty", 32'(rx_empty), 32'(rxq.size() == 0));
         if (rxq.size() != 0) chk("R8", "rx_data", 32'(rx_data), 32'(rxq[0]));
         chk("R9", "tx_full", 32'(tx_full), 32'(txq.size() == 4));
         chk("R10", "rx_ovf", 32'(rx_ovf), 32'(m_ovf));
      end
   end

   // slave data on MISO: pseudo-random, changes after each rising edge
   logic [15:0] lfsr = 16'hACE1;
   always @(posedge clk) begin
      #5;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      miso = lfsr[0];
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         mismatched++;
         $display("FAIL R5 watchdog: actual %0d cycles expected fewer than 100000", cycles);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #5;
   endtask

   task automatic push_cmd(logic [1:0] sel, logic [5:0] mask, logic [15:0] data);
      tx_word = {6'd0, sel, 2'd0, mask, data};
      tx_push = 1'b1;
      tick(1);
      tx_push = 1'b0;
   endtask

   task automatic wait_quiet();
      do tick(1);
      while (!(m_st == 0 && !m_pend && txq.size() == 0 && par_in == m_last));
      tick(3);
   endtask

   task automatic drain_rx();
      while (!rx_empty) begin
         rx_pop = 1'b1;
         tick(1);
         rx_pop = 1'b0;
         tick(1);
      end
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11", "sck", 32'(sck), 0);
      chk("R11", "mosi", 32'(mosi), 0);
      chk("R11", "cs_n", 32'(cs_n), 32'h3f);
      chk("R11", "par_out", 32'(par_out), 0);
      chk("R11", "rx_empty", 32'(rx_empty), 1);
      chk("R11", "tx_full", 32'(tx_full), 0);
      chk("R11", "rx_ovf", 32'(rx_ovf), 0);
      tick(1);

      // R1: wrong mode, then not master: nothing may start
      mode_sel = 2'b01; master_en = 1'b1; par_in = 16'hA5C3;
      tick(30);
      mode_sel = 2'b10; master_en = 1'b0;
      tick(30);
      @(negedge clk);
      chk("R1", "cs_n held", 32'(cs_n), 32'h3f);
      tick(1);

      // R3 R4 R7: serialize frame with attribute set 1, then set 2
      master_en = 1'b1;
      wait_quiet();
      par_attr_sel = 2'd2; par_in = 16'h000B;
      wait_quiet();

      // R2 R3 R6: two commands queued before a serialize change
      par_attr_sel = 2'd3;
      push_cmd(2'd0, 6'b000111, 16'hBEEF);
      push_cmd(2'd1, 6'b110000, 16'h00C5);
      par_in = 16'h0123;
      wait_quiet();
      drain_rx();

      // R9: fill while stopped, fifth push dropped
      mode_sel = 2'b00;
      push_cmd(2'd2, 6'b000001, 16'h0009);
      push_cmd(2'd3, 6'b001000, 16'h0ABC);
      push_cmd(2'd0, 6'b100001, 16'h8001);
      push_cmd(2'd1, 6'b010000, 16'h005A);
      push_cmd(2'd2, 6'b000010, 16'h0007);
      @(negedge clk);
      chk("R9", "tx_full after 5 pushes", 32'(tx_full), 1);
      tick(1);
      mode_sel = 2'b10;
      wait_quiet();

      // R10: receive FIFO full, two more results dropped
      push_cmd(2'd2, 6'b000001, 16'h0003);
      push_cmd(2'd1, 6'b001000, 16'h00F0);
      wait_quiet();
      @(negedge clk);
      chk("R10", "rx_ovf set", 32'(rx_ovf), 1);
      tick(1);
      drain_rx();
      par_in = 16'hFFFF; par_attr_sel = 2'd0;
      wait_quiet();
      tick(5);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule